// File: doc/BRIEF.md
# Fractional Cache Clock Ratio Generator

This block derives the clock for an external synchronous cache from the core clock. The cache clock runs at a programmable ratio of the core clock. A 4-bit ratio code, together with a dual-data mode bit, selects that ratio. Because the ratio can be a whole number plus one half, the block counts core half-cycles and uses both edges of the core clock. The rising edge carries the first half of each core cycle and the falling edge carries the second half.

Two outputs are produced. The first is the cache clock level. The second is a boundary strobe that is high for exactly one core half-cycle at the start of every cache clock period. Downstream control and address launch logic uses this strobe so that its outputs change only on cache-cycle boundaries.

Some settings are not allowed. These are the shortest ratio without dual-data mode, and any code outside the table. Such a setting raises an error flag. If the setting is still in force when a period would start, the generator goes idle with both outputs low. A new setting is sampled on every rising edge. It is adopted only where a cache period begins, so a period in progress is never cut short.

Top module: `cache_clk_ratio_gen`

## Requirements
- R1: Codes 0 to 5 give cache periods of 3, 4, 5, 6, 7 and 8 core half-cycles, which are ratios 1.5 to 4.0 in steps of 0.5. The period in half-cycles is the code plus 3.
- R2: Codes 6, 7, 8 and 9 give periods of 10, 12, 14 and 16 half-cycles, which are ratios 5 to 8.
- R3: Code 0 is legal only when dual_data_i is 1. With dual_data_i at 0 it is flagged as an error.
- R4: Codes 10 to 15 are always illegal.
- R5: cfg_err_o is registered. From each rising edge it reflects the setting sampled at that edge.
- R6: If the setting in force at a period start is illegal, both outputs stay low from that half-cycle on. Once a legal setting has been sampled, the next rising edge after that sample starts a period at position zero.
- R7: Each period begins with its high phase. For a period of N half-cycles, the high phase lasts ceil(N/2) half-cycles and the low phase lasts floor(N/2).
- R8: boundary_o is high for exactly the first half-cycle of each period and at no other time.
- R9: A period that starts in a given half-cycle uses the setting sampled at the latest rising edge strictly before that half-cycle. A change made in mid-period therefore does not alter the current period.
- R10: While rst_i is high, all outputs are low. After release, the first rising edge starts a period with the reset ratio 2.0 (code 1, 4 half-cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; both edges are used |
| rst_i | input | 1 | Synchronous reset, active high |
| ratio_code_i | input | 4 | Ratio code selecting the cache period |
| dual_data_i | input | 1 | Dual-data mode enable; permits code 0 |
| cache_clk_o | output | 1 | Cache clock level, one value per core half-cycle |
| boundary_o | output | 1 | One-half-cycle strobe at each cache period start |
| cfg_err_o | output | 1 | Registered illegal-setting flag |

## Verification
Every legal code is held steady and the bench measures the strobe-to-strobe distance and the high count. This separates the half-step codes from the whole-ratio codes, and the odd periods from the even ones. Code 0 is tried with dual-data mode both off and on, and out-of-table codes are also applied. Together these show whether an error flag leads to idling and a clean restart. Settings are also changed in mid-period and right at boundaries, including boundaries that fall on the falling edge. This tests whether the new ratio waits for the next period start. Every half-cycle is compared against an independent half-step model.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CODE_W  = 4;
  localparam int CNT_W   = 5;
  localparam int MAX_CODE = 9;
  localparam int SPLIT_CODE = 5;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // legality of a setting: table range, shortest ratio needs dual-data mode
  function automatic logic cfg_legal(code_t code, logic dual);
    return (code <= code_t'(MAX_CODE)) && !((code == '0) && !dual);
  endfunction

  // cache period in core half-cycles
  function automatic cnt_t period_len(code_t code);
    if (code <= code_t'(SPLIT_CODE))
      return cnt_t'(code) + cnt_t'(3);
    return (cnt_t'(code) - cnt_t'(1)) << 1;
  endfunction

  // high phase length, odd periods get the extra half-cycle
  function automatic cnt_t high_len(cnt_t len);
    return (len + cnt_t'(1)) >> 1;
  endfunction
endpackage

// File: rtl/ccr_cfg_reg.sv
module ccr_cfg_reg
  import ccr_pkg::*;
#(
  parameter int RESET_CODE = 1
) (
  input  logic  clk_i,
  input  logic  rst_i,
  input  code_t code_i,
  input  logic  dual_i,
  output logic  legal_o,
  output cnt_t  len_o,
  output logic  err_o
);
  code_t code_q;
  logic  dual_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      code_q <= code_t'(RESET_CODE);
      dual_q <= 1'b0;
    end else begin
      code_q <= code_i;
      dual_q <= dual_i;
    end
  end

  always_comb begin
    legal_o = cfg_legal(code_q, dual_q);
    len_o   = period_len(code_q);
    err_o   = !legal_o;
  end
endmodule

// File: rtl/ccr_phase_seq.sv
module ccr_phase_seq
  import ccr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_legal_i,
  input  cnt_t req_len_i,
  output logic run_o,
  output cnt_t len_o,
  output cnt_t pos_o,
  output logic lvl_a_o,
  output logic stb_a_o,
  output logic lvl_b_o,
  output logic stb_b_o
);
  logic run_q, run_d;
  cnt_t len_q, len_d, pos_q, pos_d;
  cnt_t pos_b, pos_c, hi;
  logic wrap_b;

  always_comb begin
    hi     = high_len(len_q);
    wrap_b = (pos_q + cnt_t'(1)) == len_q;
    pos_b  = wrap_b ? '0 : pos_q + cnt_t'(1);
    pos_c  = pos_b + cnt_t'(1);
    // first half of the core cycle
    lvl_a_o = run_q && (pos_q < hi);
    stb_a_o = run_q && (pos_q == '0);
    // second half: a boundary here takes the pending setting
    if (!run_q) begin
      lvl_b_o = 1'b0;
      stb_b_o = 1'b0;
    end else if (wrap_b) begin
      lvl_b_o = req_legal_i;
      stb_b_o = req_legal_i;
    end else begin
      lvl_b_o = pos_b < hi;
      stb_b_o = 1'b0;
    end
  end

  always_comb begin
    run_d = run_q;
    len_d = len_q;
    pos_d = pos_q;
    if (!run_q) begin
      if (req_legal_i) begin
        run_d = 1'b1;
        len_d = req_len_i;
        pos_d = '0;
      end
    end else if (wrap_b) begin
      if (req_legal_i) begin
        len_d = req_len_i;
        pos_d = cnt_t'(1);
      end else begin
        run_d = 1'b0;
        pos_d = '0;
      end
    end else if (pos_c == len_q) begin
      pos_d = '0;
      if (req_legal_i) len_d = req_len_i;
      else run_d = 1'b0;
    end else begin
      pos_d = pos_c;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= 1'b0;
      len_q <= cnt_t'(4);
      pos_q <= '0;
    end else begin
      run_q <= run_d;
      len_q <= len_d;
      pos_q <= pos_d;
    end
  end

  assign run_o = run_q;
  assign len_o = len_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/ccr_out_stage.sv
module ccr_out_stage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_a_i,
  input  logic stb_a_i,
  input  logic lvl_b_i,
  input  logic stb_b_i,
  output logic lvl_o,
  output logic stb_o
);
  logic lvl_b_q, stb_b_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) begin
      lvl_b_q <= 1'b0;
      stb_b_q <= 1'b0;
    end else begin
      lvl_b_q <= lvl_b_i;
      stb_b_q <= stb_b_i;
    end
  end

  assign lvl_o = clk_i ? lvl_a_i : lvl_b_q;
  assign stb_o = clk_i ? stb_a_i : stb_b_q;
endmodule

// File: rtl/cache_clk_ratio_gen.sv
module cache_clk_ratio_gen
  import ccr_pkg::*;
#(
  parameter int RESET_CODE = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              dual_data_i,
  output logic              cache_clk_o,
  output logic              boundary_o,
  output logic              cfg_err_o
);
  logic req_legal_w;
  cnt_t req_len_w;
  logic run_w;
  cnt_t len_w, pos_w;
  logic lvl_a_w, stb_a_w, lvl_b_w, stb_b_w;

  ccr_cfg_reg #(.RESET_CODE(RESET_CODE)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i), .code_i(ratio_code_i), .dual_i(dual_data_i),
    .legal_o(req_legal_w), .len_o(req_len_w), .err_o(cfg_err_o)
  );

  ccr_phase_seq u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .req_legal_i(req_legal_w), .req_len_i(req_len_w),
    .run_o(run_w), .len_o(len_w), .pos_o(pos_w),
    .lvl_a_o(lvl_a_w), .stb_a_o(stb_a_w), .lvl_b_o(lvl_b_w), .stb_b_o(stb_b_w)
  );

  ccr_out_stage u_out (
    .clk_i(clk_i), .rst_i(rst_i), .lvl_a_i(lvl_a_w), .stb_a_i(stb_a_w),
    .lvl_b_i(lvl_b_w), .stb_b_i(stb_b_w), .lvl_o(cache_clk_o), .stb_o(boundary_o)
  );
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker
  import ccr_pkg::*;
(
  input logic  clk_i,
  input logic  rst_i,
  input code_t ratio_code_i,
  input logic  dual_data_i,
  input logic  cfg_err_o,
  input logic  run_w,
  input cnt_t  len_w,
  input cnt_t  pos_w,
  input logic  lvl_a_w,
  input logic  stb_a_w
);
  AST_SHORT_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    run_w && len_w <= cnt_t'(8) |-> len_w >= cnt_t'(3)); // R1
  AST_LONG_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    run_w && len_w > cnt_t'(8) |-> !len_w[0] && len_w <= cnt_t'(16)); // R2
  AST_ERR_SHORT: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i) && $past(ratio_code_i == '0 && !dual_data_i) |-> cfg_err_o); // R3
  AST_ERR_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!rst_i) && $past(ratio_code_i > code_t'(9)) |-> cfg_err_o); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_w |-> !lvl_a_w && !stb_a_w); // R6
  AST_START_POS: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(run_w) |-> pos_w == '0 && stb_a_w); // R6
  AST_POS_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    run_w |-> pos_w < len_w); // R7
  AST_STROBE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    stb_a_w |-> lvl_a_w); // R8
  AST_LEN_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    run_w && $past(run_w) && pos_w >= cnt_t'(2) |-> $stable(len_w)); // R9
endmodule

bind cache_clk_ratio_gen ccr_checker u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .ratio_code_i(ratio_code_i), .dual_data_i(dual_data_i),
  .cfg_err_o(cfg_err_o), .run_w(run_w), .len_w(len_w), .pos_w(pos_w),
  .lvl_a_w(lvl_a_w), .stb_a_w(stb_a_w)
);

// File: tb/cache_clk_ratio_gen_tb.sv
module cache_clk_ratio_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] code = 4'd1;
  logic       dd = 1'b0;
  logic       cclk, stb, err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // half-step reference model
  bit m_run = 0; int m_len = 4, m_pos = 0;
  logic [3:0] mq_code = 4'd1; logic mq_dd = 1'b0;
  bit next_rise = 1;

  always #4 clk = ~clk; // 125 MHz

  cache_clk_ratio_gen u_dut (
    .clk_i(clk), .rst_i(rst), .ratio_code_i(code), .dual_data_i(dd),
    .cache_clk_o(cclk), .boundary_o(stb), .cfg_err_o(err)
  );

  function automatic int ref_len(logic [3:0] c);
    case (c)
      4'd0: return 3;  4'd1: return 4;  4'd2: return 5;  4'd3: return 6;
      4'd4: return 7;  4'd5: return 8;  4'd6: return 10; 4'd7: return 12;
      4'd8: return 14; 4'd9: return 16; default: return 0;
    endcase
  endfunction

  function automatic bit ref_ok(logic [3:0] c, logic d);
    return ref_len(c) != 0 && (c != 4'd0 || d);
  endfunction

  task automatic check(bit cond, string tag, int act, int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(bit rising);
    if (m_run) begin
      m_pos++;
      if (m_pos == m_len) begin
        m_pos = 0;
        if (ref_ok(mq_code, mq_dd)) m_len = ref_len(mq_code);
        else m_run = 0;
      end
    end else if (rising && ref_ok(mq_code, mq_dd)) begin
      m_run = 1; m_len = ref_len(mq_code); m_pos = 0;
    end
  endtask

  task automatic hstep(string tag);
    bit ec, es, ee;
    if (next_rise) @(posedge clk); else @(negedge clk);
    if (!rst) model_step(next_rise);
    if (next_rise && !rst) begin mq_code = code; mq_dd = dd; end
    next_rise = !next_rise;
    #2;
    ec = m_run && (m_pos < (m_len + 1) / 2);
    es = m_run && (m_pos == 0);
    ee = !ref_ok(mq_code, mq_dd);
    check(cclk == ec, {tag, " cache_clk"}, cclk, ec);
    check(stb == es, {tag, " boundary"}, stb, es);
    check(err == ee, {tag, " err"}, err, ee);
  endtask

  task automatic run_halves(int n, string tag);
    for (int i = 0; i < n; i++) hstep(tag);
  endtask

  // R10: reset state and start at ratio 2.0
  task automatic t_reset();
    rst = 1'b1;
    run_halves(6, "R10 reset");
    rst = 1'b0;
    run_halves(12, "R10 start");
  endtask

  // R1 R2 R7 R8: period and high length for one legal setting
  task automatic t_ratio(logic [3:0] c, logic d, int exp_len, string tag);
    int len, hi, guard;
    code = c; dd = d;
    run_halves(40, tag);
    guard = 0;
    while (!stb && guard < 40) begin hstep(tag); guard++; end
    len = 1; hi = 1;
    for (int i = 0; i < 40; i++) begin
      hstep(tag);
      if (stb) break;
      len++;
      hi += cclk;
    end
    check(len == exp_len, {tag, " period"}, len, exp_len);
    check(hi == (exp_len + 1) / 2, "R7 high phase", hi, (exp_len + 1) / 2);
  endtask

  // R4 R6: out-of-table code idles, legal code restarts
  task automatic t_illegal();
    code = 4'd13; dd = 1'b1;
    run_halves(40, "R4 R6 idle");
    check(cclk == 1'b0 && err == 1'b1, "R6 idle low", cclk, 0);
    code = 4'd2;
    run_halves(20, "R6 restart");
  endtask

  // R3: shortest ratio needs dual-data mode
  task automatic t_dual();
    code = 4'd0; dd = 1'b0;
    run_halves(30, "R3 no dual");
    check(err == 1'b1, "R3 flag", err, 1);
    dd = 1'b1;
    run_halves(2, "R5 flag clears");
    check(err == 1'b0, "R5 flag", err, 0);
    run_halves(20, "R3 dual");
  endtask

  // R9: changes at many phase offsets only act at period starts
  task automatic t_change();
    for (int k = 0; k < 12; k++) begin
      code = 4'd9; dd = 1'b1;
      run_halves(5 + k, "R9 long");
      code = 4'd0;
      run_halves(7 + k, "R9 short");
      code = 4'd4;
      run_halves(3, "R9 odd");
      code = 4'd15;
      run_halves(2, "R9 glitch");
    end
    code = 4'd1;
    run_halves(40, "R9 settle");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratio(4'd0, 1'b1, 3, "R1 1.5");
    t_ratio(4'd1, 1'b0, 4, "R1 2.0");
    t_ratio(4'd2, 1'b0, 5, "R1 2.5");
    t_ratio(4'd3, 1'b0, 6, "R1 3.0");
    t_ratio(4'd4, 1'b0, 7, "R1 3.5");
    t_ratio(4'd5, 1'b0, 8, "R1 4.0");
    t_ratio(4'd6, 1'b0, 10, "R2 5");
    t_ratio(4'd7, 1'b0, 12, "R2 6");
    t_ratio(4'd8, 1'b1, 14, "R2 7");
    t_ratio(4'd9, 1'b0, 16, "R2 8");
    t_illegal();
    t_dual();
    t_change();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule